// File: doc/BRIEF.md
# Conflict-Tolerant Memory Request Reorder Queue

This block sits between the instruction issue stage and the cache port of a load/store unit. It holds up to eight memory requests, each tagged with a warp number, a load/store flag and an address. Each cycle it presents one request to the cache. In the same cycle the cache answers with accept, reject or neither.

When the cache turns a request away because every miss-tracking slot is busy, or because the target set has no free way, the request is not dropped. It is marked stalled and stays in the queue, and requests from other warps are allowed to pass it. A stalled request rests for one cycle. After that it is retried ahead of all non-stalled work. Requests belonging to the same warp as an older queued request never overtake it, so the order of each warp's memory operations is kept.

A rejection with any other cause leaves the request in its normal place, to be offered again. An entry leaves the queue only when the cache accepts it. In that cycle a retire pulse reports the warp and the load/store type that left.

Top module: `lsu_conflict_reorder`

## Requirements
- R1: After reset the queue is empty: `req_valid` is 0 and `in_ready` is 1.
- R2: A request is written into the queue in a cycle where `in_valid` and `in_ready` are both 1, and it can be presented from the next cycle. When there are no rejections, requests are presented and retired in arrival order.
- R3: `in_ready` is 0 while all DEPTH entries are held, and a request offered in that state is dropped without effect.
- R4: A rejection with cause 2'b01 (miss slots full) or 2'b10 (set conflict) keeps the entry and marks it stalled. The entry is not presented in the next cycle, and younger eligible entries from other warps are presented in its place.
- R5: No entry is presented while an older entry of the same warp is held in the queue, whether or not that older entry is stalled.
- R6: From the second cycle after its rejection, a stalled entry is presented ahead of every non-stalled entry. When several stalled entries are ready, the oldest is presented first.
- R7: A rejection with cause 2'b00 or 2'b11 leaves the entry non-stalled and in its age position, so it is presented again in the next cycle if it is still the oldest eligible entry.
- R8: An entry is freed only when `rsp_accept` is 1 while it is presented. In that same cycle `retire_valid` is 1 and `retire_warp` and `retire_store` carry that entry's warp and type.
- R9: `rsp_accept` and `rsp_reject` have no effect in a cycle where `req_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | New request offered |
| in_ready | output | 1 | Queue can take a request |
| in_warp | input | WARP_W | Warp number of the new request |
| in_store | input | 1 | 1 for a store, 0 for a load |
| in_addr | input | ADDR_W | Address of the new request |
| req_valid | output | 1 | A request is presented to the cache |
| req_warp | output | WARP_W | Warp of the presented request |
| req_store | output | 1 | Type of the presented request |
| req_addr | output | ADDR_W | Address of the presented request |
| rsp_accept | input | 1 | Cache takes the presented request this cycle |
| rsp_reject | input | 1 | Cache turns the presented request away this cycle |
| rsp_cause | input | 2 | Reject reason: 01 miss slots full, 10 set conflict, others transient |
| retire_valid | output | 1 | A request left the queue this cycle |
| retire_warp | output | WARP_W | Warp of the retired request |
| retire_store | output | 1 | Type of the retired request |

## Verification
A stalled bit that is lost or never set shows up one cycle after the rejection: the rejected address is presented again at once, or a younger request from the same warp appears. A broken age order or a broken warp-blocking mask shows up as the wrong address at the first cycle the cache answers. A wrong count or a compaction error corrupts the queue contents. That shows within the following accepts, as a missing, duplicated or reordered address during the drain, or as `in_ready` staying high past eight entries.

// File: rtl/lsu_conflict_reorder.sv
module lsu_conflict_reorder #(
  parameter int DEPTH  = 8,
  parameter int WARP_W = 5,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WARP_W-1:0] in_warp,
  input  logic              in_store,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              req_valid,
  output logic [WARP_W-1:0] req_warp,
  output logic              req_store,
  output logic [ADDR_W-1:0] req_addr,
  input  logic              rsp_accept,
  input  logic              rsp_reject,
  input  logic [1:0]        rsp_cause,
  output logic              retire_valid,
  output logic [WARP_W-1:0] retire_warp,
  output logic              retire_store
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [1:0] CAUSE_MSHR = 2'b01;
  localparam logic [1:0] CAUSE_SET  = 2'b10;

  logic [DEPTH-1:0]  v_q, stl_q, wt_q, st_q;
  logic [WARP_W-1:0] warp_q [DEPTH];
  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [CNT_W-1:0]  cnt_q;

  logic [DEPTH-1:0]  v_n, stl_n, wt_n, st_n;
  logic [WARP_W-1:0] warp_n [DEPTH];
  logic [ADDR_W-1:0] addr_n [DEPTH];
  logic [CNT_W-1:0]  cnt_n;

  logic [DEPTH-1:0] blk, rdy_stl, rdy_new;
  logic             sel_hit;
  logic [IDX_W-1:0] sel;
  logic             take, hold, conflict, push;
  logic [CNT_W-1:0] ins;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      blk[i] = 1'b0;
      for (int j = 0; j < DEPTH; j++)
        if (j < i && v_q[j] && warp_q[j] == warp_q[i]) blk[i] = 1'b1;
      rdy_stl[i] = v_q[i] & stl_q[i] & ~wt_q[i] & ~blk[i];
      rdy_new[i] = v_q[i] & ~stl_q[i] & ~blk[i];
    end
  end

  always_comb begin
    sel_hit = 1'b0;
    sel     = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (rdy_new[i]) begin sel_hit = 1'b1; sel = IDX_W'(i); end
    for (int i = DEPTH - 1; i >= 0; i--)
      if (rdy_stl[i]) begin sel_hit = 1'b1; sel = IDX_W'(i); end
  end

  assign in_ready  = cnt_q != CNT_W'(DEPTH);
  assign push      = in_valid && in_ready;
  assign req_valid = sel_hit;
  assign req_warp  = warp_q[sel];
  assign req_store = st_q[sel];
  assign req_addr  = addr_q[sel];
  assign take      = sel_hit && rsp_accept;
  assign hold      = sel_hit && !rsp_accept && rsp_reject;
  assign conflict  = hold && (rsp_cause == CAUSE_MSHR || rsp_cause == CAUSE_SET);
  assign ins       = cnt_q - CNT_W'(take);

  assign retire_valid = take;
  assign retire_warp  = req_warp;
  assign retire_store = req_store;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      int s;
      s = (take && i >= int'(sel)) ? i + 1 : i;
      if (s < DEPTH) begin
        v_n[i]    = v_q[s[IDX_W-1:0]];
        stl_n[i]  = stl_q[s[IDX_W-1:0]];
        st_n[i]   = st_q[s[IDX_W-1:0]];
        warp_n[i] = warp_q[s[IDX_W-1:0]];
        addr_n[i] = addr_q[s[IDX_W-1:0]];
      end else begin
        v_n[i]    = 1'b0;
        stl_n[i]  = 1'b0;
        st_n[i]   = 1'b0;
        warp_n[i] = '0;
        addr_n[i] = '0;
      end
      wt_n[i] = 1'b0;
    end
    if (conflict) begin
      stl_n[sel] = 1'b1;
      wt_n[sel]  = 1'b1;
    end
    if (push) begin
      v_n[ins[IDX_W-1:0]]    = 1'b1;
      stl_n[ins[IDX_W-1:0]]  = 1'b0;
      wt_n[ins[IDX_W-1:0]]   = 1'b0;
      st_n[ins[IDX_W-1:0]]   = in_store;
      warp_n[ins[IDX_W-1:0]] = in_warp;
      addr_n[ins[IDX_W-1:0]] = in_addr;
    end
    cnt_n = ins + CNT_W'(push);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q   <= '0;
      stl_q <= '0;
      wt_q  <= '0;
      st_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        warp_q[i] <= '0;
        addr_q[i] <= '0;
      end
    end else begin
      v_q   <= v_n;
      stl_q <= stl_n;
      wt_q  <= wt_n;
      st_q  <= st_n;
      cnt_q <= cnt_n;
      for (int i = 0; i < DEPTH; i++) begin
        warp_q[i] <= warp_n[i];
        addr_q[i] <= addr_n[i];
      end
    end
  end
endmodule

// File: rtl/lsu_conflict_reorder_chk.sv
module lsu_conflict_reorder_chk #(
  parameter int DEPTH  = 8,
  parameter int WARP_W = 5
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         in_valid,
  input logic                         in_ready,
  input logic                         req_valid,
  input logic [WARP_W-1:0]            req_warp,
  input logic                         rsp_accept,
  input logic                         rsp_reject,
  input logic [1:0]                   rsp_cause,
  input logic                         retire_valid,
  input logic [DEPTH-1:0]             v,
  input logic [$clog2(DEPTH+1)-1:0]   cnt
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  logic [DEPTH:0] packed_mask;
  assign packed_mask = ((DEPTH+1)'(1) << cnt) - (DEPTH+1)'(1);

  assert_empty_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (cnt == '0 && !req_valid));

  assert_entries_packed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    v == packed_mask[DEPTH-1:0]);

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(DEPTH));

  assert_full_drops_input_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> cnt <= $past(cnt));

  assert_stall_blocks_warp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !rsp_accept && rsp_reject && (rsp_cause == 2'b01 || rsp_cause == 2'b10))
    |=> !(req_valid && req_warp == $past(req_warp)));

  assert_retire_needs_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    retire_valid |-> req_valid);

  assert_free_only_on_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && rsp_accept) |=> cnt >= $past(cnt));

  assert_idle_reply_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid && !in_valid) |=> cnt == $past(cnt));
endmodule

bind lsu_conflict_reorder lsu_conflict_reorder_chk #(.DEPTH(DEPTH), .WARP_W(WARP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .req_valid(req_valid), .req_warp(req_warp), .rsp_accept(rsp_accept),
  .rsp_reject(rsp_reject), .rsp_cause(rsp_cause), .retire_valid(retire_valid),
  .v(v_q), .cnt(cnt_q)
);

// File: tb/lsu_conflict_reorder_tb.sv
module lsu_conflict_reorder_tb;
  localparam int DEPTH = 8, WARP_W = 5, ADDR_W = 32;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_store = 0, in_ready;
  logic [WARP_W-1:0] in_warp = '0;
  logic [ADDR_W-1:0] in_addr = '0;
  logic req_valid, req_store;
  logic [WARP_W-1:0] req_warp;
  logic [ADDR_W-1:0] req_addr;
  logic rsp_accept = 0, rsp_reject = 0;
  logic [1:0] rsp_cause = 2'b00;
  logic retire_valid, retire_store;
  logic [WARP_W-1:0] retire_warp;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  lsu_conflict_reorder #(.DEPTH(DEPTH), .WARP_W(WARP_W), .ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_warp(in_warp), .in_store(in_store), .in_addr(in_addr),
    .req_valid(req_valid), .req_warp(req_warp), .req_store(req_store), .req_addr(req_addr),
    .rsp_accept(rsp_accept), .rsp_reject(rsp_reject), .rsp_cause(rsp_cause),
    .retire_valid(retire_valid), .retire_warp(retire_warp), .retire_store(retire_store));

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [WARP_W-1:0] w, input logic s, input logic [ADDR_W-1:0] a);
    in_valid = 1; in_warp = w; in_store = s; in_addr = a;
    @(posedge clk); @(negedge clk);
    in_valid = 0;
  endtask

  task automatic serve(input string tag, input logic [WARP_W-1:0] w, input logic [ADDR_W-1:0] a,
                       input logic s, input logic acc, input logic rej, input logic [1:0] cause);
    chk(req_valid && req_addr == a && req_warp == w && req_store == s, tag,
        {req_valid, req_warp, req_addr}, {1'b1, w, a});
    rsp_accept = acc; rsp_reject = rej; rsp_cause = cause;
    #1;
    if (acc) chk(retire_valid && retire_warp == w && retire_store == s, {tag, " retire"},
                 {retire_valid, retire_warp, retire_store}, {1'b1, w, s});
    @(posedge clk); @(negedge clk);
    rsp_accept = 0; rsp_reject = 0; rsp_cause = 2'b00;
  endtask

  task automatic idle(input string tag);
    chk(!req_valid, tag, req_valid, 0);
  endtask

  task automatic t_reset;
    chk(!req_valid && in_ready, "R1 reset state", {req_valid, in_ready}, 2'b01);
  endtask

  task automatic t_fifo;
    push(1, 0, 32'h10); push(2, 1, 32'h20); push(3, 0, 32'h30);
    serve("R2 fifo first", 1, 32'h10, 0, 1, 0, 2'b00);
    serve("R2 fifo second R8", 2, 32'h20, 1, 1, 0, 2'b00);
    serve("R2 fifo third", 3, 32'h30, 0, 1, 0, 2'b00);
    idle("R2 drained");
  endtask

  task automatic t_full;
    for (int i = 0; i < DEPTH; i++) push(WARP_W'(i), 0, ADDR_W'(32'h100 + i));
    chk(!in_ready, "R3 full backpressure", in_ready, 0);
    push(9, 1, 32'h999);
    for (int i = 0; i < DEPTH; i++)
      serve("R3 drain after full", WARP_W'(i), ADDR_W'(32'h100 + i), 0, 1, 0, 2'b00);
    idle("R3 dropped request absent");
    chk(in_ready, "R3 ready after drain", in_ready, 1);
  endtask

  task automatic t_conflict;
    push(1, 0, 32'h1); push(1, 1, 32'h2); push(2, 0, 32'h3);
    serve("R4 head rejected mshr", 1, 32'h1, 0, 0, 1, 2'b01);
    serve("R4 R5 other warp bypasses", 2, 32'h3, 0, 0, 0, 2'b00);
    serve("R6 stalled retried first", 1, 32'h1, 0, 1, 0, 2'b00);
    serve("R5 same warp follows", 1, 32'h2, 1, 1, 0, 2'b00);
    serve("R4 bypasser retires", 2, 32'h3, 0, 1, 0, 2'b00);
    idle("R4 drained");
  endtask

  task automatic t_ignore_idle;
    push(5, 0, 32'h7);
    serve("R4 rejected set conflict", 5, 32'h7, 0, 0, 1, 2'b10);
    idle("R4 rest cycle");
    rsp_accept = 1; rsp_reject = 1;
    @(posedge clk); @(negedge clk);
    rsp_accept = 0; rsp_reject = 0;
    serve("R9 response ignored while idle", 5, 32'h7, 0, 1, 0, 2'b00);
    idle("R9 drained");
  endtask

  task automatic t_transient;
    push(1, 0, 32'h11); push(2, 0, 32'h12);
    serve("R7 transient cause 00", 1, 32'h11, 0, 0, 1, 2'b00);
    serve("R7 retried at once", 1, 32'h11, 0, 0, 1, 2'b11);
    serve("R7 retried after cause 11", 1, 32'h11, 0, 1, 0, 2'b00);
    serve("R7 next entry", 2, 32'h12, 0, 1, 0, 2'b00);
    idle("R7 drained");
  endtask

  task automatic t_two_stalled;
    push(1, 0, 32'h21); push(2, 0, 32'h22); push(3, 1, 32'h23);
    serve("R6 first stall", 1, 32'h21, 0, 0, 1, 2'b01);
    serve("R6 second stall", 2, 32'h22, 0, 0, 1, 2'b10);
    serve("R6 ready stalled beats waiting", 1, 32'h21, 0, 0, 0, 2'b00);
    serve("R6 oldest stalled first", 1, 32'h21, 0, 1, 0, 2'b00);
    serve("R6 second stalled next", 2, 32'h22, 0, 1, 0, 2'b00);
    serve("R6 plain entry last", 3, 32'h23, 1, 1, 0, 2'b00);
    idle("R6 drained");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_fifo;
    t_full;
    t_conflict;
    t_ignore_idle;
    t_transient;
    t_two_stalled;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule